// File: doc/BRIEF.md
# Board Control Register Glue

This block is the small control logic that sits on a board's asynchronous 8-bit memory bus, inside a chip-enable space that it shares with a flash device. The highest bus address bit splits that space: with the bit clear the access belongs to the flash, which gets its own chip enable, and with the bit set the access lands in a window of four 8-bit control registers. Through those registers software reads the user switches, the daughter-card presence and status lines and a fixed revision byte. It also drives the user LEDs, the daughter-card control lines and card reset, the two serial-port route selects and one extra flash address bit.

The block also merges the board reset sources (push button, one or more power supervisors, the debug emulator reset) into a single global reset. Each source is synchronised, and the global reset stays asserted for a fixed number of clocks after the last source lets go. The global reset returns every writable field to its power-on value. The daughter card is held in reset whenever the global reset is active, and software can hold it in reset afterwards.

Bus writes take effect on the rising edge of the write strobe, which is sampled in the clock domain. Reads are combinational from the register state and the synchronised inputs. Address, data and chip enable must stay steady for at least three clocks after the write strobe rises.

Top module: `board_glue_top`

## Requirements
- R1: `flash_ce_n` is low exactly when `bus_ce_n` is low and the top address bit is 0. The register window is selected when `bus_ce_n` is low and the top address bit is 1.
- R2: `bus_rdata_oe` is high only while the register window is selected and `bus_re_n` is low. `bus_rdata` is 0 whenever `bus_rdata_oe` is low.
- R3: Register index 0 (address bits [1:0]) reads switches in bits [7:4] and the LED field in bits [3:0]. Writing bits [3:0] sets `led`, and the switch field is read-only.
- R4: Register index 1 reads the card hold bit in bit 7, card detect in bit 4, card status in bits [3:2] and card control in bits [1:0]. Only bits 7 and [1:0] are writable, and bits [1:0] drive `card_ctl`.
- R5: `card_rst_n` is low whenever the global reset is active or the card hold bit is 1, and high otherwise.
- R6: Register index 2 reads {0, LOGIC_REV[2:0], BOARD_REV[3:0]}, and writes to it change nothing.
- R7: Register index 3 holds route selects in bits [1:0] (0 = on-board codec, 1 = expansion connector), the flash page bit in bit 2 and four scratch bits in [7:4]. All of these read back as written and drive `route_sel` and `flash_page`.
- R8: A write changes a register at the second rising clock edge after the first edge that samples `bus_we_n` high following a low period. The write happens only if the register window is selected at that edge.
- R9: `sys_rst_n` goes low at the second clock edge after an edge that samples any reset source low. It returns high HOLD_CYCLES+2 edges after the first edge of an unbroken run of samples with every source high.
- R10: While the global reset is active, and on the edge after it, LED, card control, card hold, route, page and scratch fields are all 0.
- R11: Bits with no defined field read as 0: bits [6:5] of index 1, bit 7 of index 2 and bit 3 of index 3.
- R12: Switch, card detect and card status inputs appear in read data two clock edges after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| btn_rst_n | input | 1 | Push-button reset, active low |
| sup_rst_n | input | NUM_SUP | Power supervisor resets, active low |
| emu_rst_n | input | 1 | Debug emulator reset, active low |
| bus_ce_n | input | 1 | Shared chip enable, active low |
| bus_addr | input | ADDR_W | Word address; top bit selects registers |
| bus_re_n | input | 1 | Read strobe, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| bus_rdata_oe | output | 1 | Read data drive enable |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| sw_in | input | 4 | User switch levels |
| card_det | input | 1 | Daughter-card presence |
| card_stat | input | 2 | Daughter-card status lines |
| led | output | 4 | User LEDs |
| card_ctl | output | 2 | Daughter-card control lines |
| card_rst_n | output | 1 | Daughter-card reset, active low |
| route_sel | output | 2 | Serial-port route selects |
| flash_page | output | 1 | Extra flash address bit |
| sys_rst_n | output | 1 | Global reset, active low |

## Verification
Three latencies govern the block: register writes land two edges after the first edge that samples the write strobe high, inputs show in read data two edges after they change, and the global reset asserts two edges after a low sample and releases HOLD_CYCLES+2 edges after sources clear. The bench keeps a queue of sampled strobe and reset-source levels and derives every expected output from the right entry of that history. It compares all control outputs at the falling edge of every cycle, so a result one edge early or late is reported. Reads are combinational and are checked in the same cycle the address is driven, after allowing the two-edge input delay.

// File: rtl/board_glue_pkg.sv
package board_glue_pkg;

    localparam int SW_W   = 4;
    localparam int CTL_W  = 2;
    localparam int STAT_W = 2;
    localparam int NPORT  = 2;

    typedef enum logic [1:0] {
        IDX_USER = 2'd0,
        IDX_CARD = 2'd1,
        IDX_VER  = 2'd2,
        IDX_MISC = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [SW_W-1:0]  led;
        logic [CTL_W-1:0] card_ctl;
        logic             card_hold;
        logic [NPORT-1:0] route;
        logic             page;
        logic [3:0]       scratch;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RESET = '0;

    function automatic logic [7:0] pack_card(input logic hold, input logic det,
                                             input logic [STAT_W-1:0] stat,
                                             input logic [CTL_W-1:0] ctl);
        return {hold, 2'b00, det, stat, ctl};
    endfunction

    function automatic logic [7:0] pack_misc(input logic [3:0] scratch, input logic page,
                                             input logic [NPORT-1:0] route);
        return {scratch, 1'b0, page, route};
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_combiner.sv
module rst_combiner #(
    parameter int NSRC = 3,
    parameter int HOLD = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_n,
    output logic            sys_rst
);
    localparam int CW = $clog2(HOLD + 1);

    logic [NSRC-1:0] src_s;
    logic [CW-1:0]   cnt;
    logic            rst_q;

    bit_sync #(.W(NSRC), .STAGES(2), .RST_VAL('0)) u_sync (
        .clk(clk), .rst(rst), .d(src_n), .q(src_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= CW'(HOLD);
            rst_q <= 1'b1;
        end else if (!(&src_s)) begin
            cnt   <= CW'(HOLD);
            rst_q <= 1'b1;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
            rst_q <= 1'b1;
        end else begin
            rst_q <= 1'b0;
        end
    end

    assign sys_rst = rst_q;
endmodule

// File: rtl/bus_regs.sv
module bus_regs
    import board_glue_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter logic [3:0] BOARD_REV = 4'h2,
    parameter logic [2:0] LOGIC_REV = 3'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_rst,
    input  logic              bus_ce_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_re_n,
    input  logic              bus_we_n,
    input  logic [7:0]        bus_wdata,
    input  logic [SW_W-1:0]   sw_s,
    input  logic              det_s,
    input  logic [STAT_W-1:0] stat_s,
    output ctrl_regs_t        regs,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    output logic              wr_pulse
);
    logic     win_sel;
    logic     we_s;
    logic     we_d;
    reg_idx_e idx;
    logic [7:0] rd;

    assign win_sel = !bus_ce_n && bus_addr[ADDR_W-1];
    assign idx     = reg_idx_e'(bus_addr[1:0]);

    bit_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_we_sync (
        .clk(clk), .rst(rst), .d(bus_we_n), .q(we_s)
    );

    always_ff @(posedge clk) begin
        if (rst) we_d <= 1'b1;
        else     we_d <= we_s;
    end

    assign wr_pulse = we_s && !we_d && win_sel;

    always_ff @(posedge clk) begin
        if (rst || sys_rst) begin
            regs <= CTRL_RESET;
        end else if (wr_pulse) begin
            case (idx)
                IDX_USER: regs.led <= bus_wdata[SW_W-1:0];
                IDX_CARD: begin
                    regs.card_ctl  <= bus_wdata[CTL_W-1:0];
                    regs.card_hold <= bus_wdata[7];
                end
                IDX_MISC: begin
                    regs.route   <= bus_wdata[NPORT-1:0];
                    regs.page    <= bus_wdata[2];
                    regs.scratch <= bus_wdata[7:4];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_USER: rd = {sw_s, regs.led};
            IDX_CARD: rd = pack_card(regs.card_hold, det_s, stat_s, regs.card_ctl);
            IDX_VER:  rd = {1'b0, LOGIC_REV, BOARD_REV};
            default:  rd = pack_misc(regs.scratch, regs.page, regs.route);
        endcase
    end

    assign rdata_oe = win_sel && !bus_re_n;
    assign rdata    = rdata_oe ? rd : 8'h00;
endmodule

// File: rtl/board_glue_top.sv
module board_glue_top
    import board_glue_pkg::*;
#(
    parameter int NUM_SUP = 2,
    parameter int HOLD_CYCLES = 8,
    parameter int ADDR_W = 3,
    parameter logic [3:0] BOARD_REV = 4'h2,
    parameter logic [2:0] LOGIC_REV = 3'h1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_rst_n,
    input  logic [NUM_SUP-1:0] sup_rst_n,
    input  logic               emu_rst_n,
    input  logic               bus_ce_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_re_n,
    input  logic               bus_we_n,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               bus_rdata_oe,
    output logic               flash_ce_n,
    input  logic [3:0]         sw_in,
    input  logic               card_det,
    input  logic [1:0]         card_stat,
    output logic [3:0]         led,
    output logic [1:0]         card_ctl,
    output logic               card_rst_n,
    output logic [1:0]         route_sel,
    output logic               flash_page,
    output logic               sys_rst_n
);
    localparam int NSRC = NUM_SUP + 2;
    localparam int IN_W = SW_W + 1 + STAT_W;

    logic             sys_rst;
    logic             wr_pulse;
    ctrl_regs_t       regs;
    logic [IN_W-1:0]  in_s;

    rst_combiner #(.NSRC(NSRC), .HOLD(HOLD_CYCLES)) u_rst (
        .clk(clk), .rst(rst),
        .src_n({emu_rst_n, sup_rst_n, btn_rst_n}),
        .sys_rst(sys_rst)
    );

    bit_sync #(.W(IN_W), .STAGES(2), .RST_VAL('0)) u_in_sync (
        .clk(clk), .rst(rst),
        .d({sw_in, card_det, card_stat}), .q(in_s)
    );

    bus_regs #(.ADDR_W(ADDR_W), .BOARD_REV(BOARD_REV), .LOGIC_REV(LOGIC_REV)) u_regs (
        .clk(clk), .rst(rst), .sys_rst(sys_rst),
        .bus_ce_n(bus_ce_n), .bus_addr(bus_addr), .bus_re_n(bus_re_n),
        .bus_we_n(bus_we_n), .bus_wdata(bus_wdata),
        .sw_s(in_s[IN_W-1 -: SW_W]), .det_s(in_s[STAT_W]), .stat_s(in_s[STAT_W-1:0]),
        .regs(regs), .rdata(bus_rdata), .rdata_oe(bus_rdata_oe), .wr_pulse(wr_pulse)
    );

    assign flash_ce_n = bus_ce_n || bus_addr[ADDR_W-1];
    assign led        = regs.led;
    assign card_ctl   = regs.card_ctl;
    assign card_rst_n = !(sys_rst || regs.card_hold);
    assign route_sel  = regs.route;
    assign flash_page = regs.page;
    assign sys_rst_n  = !sys_rst;
endmodule

// File: rtl/board_glue_chk.sv
module board_glue_chk #(
    parameter int NUM_SUP = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               btn_rst_n,
    input logic [NUM_SUP-1:0] sup_rst_n,
    input logic               emu_rst_n,
    input logic               bus_re_n,
    input logic               bus_rdata_oe,
    input logic [7:0]         bus_rdata,
    input logic               flash_ce_n,
    input logic               card_rst_n,
    input logic               sys_rst_n,
    input logic               wr_pulse,
    input logic [3:0]         led,
    input logic [1:0]         route_sel,
    input logic               flash_page
);
    logic all_rel;
    assign all_rel = btn_rst_n && emu_rst_n && (&sup_rst_n);

    AST_FLASH_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !flash_ce_n |-> !bus_rdata_oe); // R1

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        bus_re_n |-> (!bus_rdata_oe && bus_rdata == 8'h00)); // R2

    AST_CARD_HELD: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_n |-> !card_rst_n); // R5

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_pulse && sys_rst_n) |=> $stable(led)); // R8

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        !sys_rst_n |=> (led == 4'h0 && route_sel == 2'b00 && !flash_page)); // R10

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> ($past(all_rel, 3) && $past(all_rel, 4))); // R9
endmodule

bind board_glue_top board_glue_chk #(.NUM_SUP(NUM_SUP)) chk_i (
    .clk(clk), .rst(rst), .btn_rst_n(btn_rst_n), .sup_rst_n(sup_rst_n),
    .emu_rst_n(emu_rst_n), .bus_re_n(bus_re_n), .bus_rdata_oe(bus_rdata_oe),
    .bus_rdata(bus_rdata), .flash_ce_n(flash_ce_n), .card_rst_n(card_rst_n),
    .sys_rst_n(sys_rst_n), .wr_pulse(wr_pulse), .led(led),
    .route_sel(route_sel), .flash_page(flash_page)
);

// File: tb/board_glue_top_tb_top.sv
`timescale 1ns/1ps
module board_glue_top_tb_top;
    localparam int NUM_SUP = 2;
    localparam int HOLD = 8;
    localparam int ADDR_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_rst_n = 1'b1;
    logic [NUM_SUP-1:0] sup_rst_n = '1;
    logic emu_rst_n = 1'b1;
    logic bus_ce_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic bus_re_n = 1'b1;
    logic bus_we_n = 1'b1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic bus_rdata_oe, flash_ce_n;
    logic [3:0] sw_in = 4'h0;
    logic card_det = 1'b0;
    logic [1:0] card_stat = 2'b00;
    logic [3:0] led;
    logic [1:0] card_ctl;
    logic card_rst_n;
    logic [1:0] route_sel;
    logic flash_page, sys_rst_n;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    board_glue_top #(.NUM_SUP(NUM_SUP), .HOLD_CYCLES(HOLD), .ADDR_W(ADDR_W),
                     .BOARD_REV(4'h2), .LOGIC_REV(3'h1)) dut_i (.*);

    // behavioural reference: histories of sampled levels
    bit srcq[$];
    bit weq[$];
    bit       m_sys = 1'b1;
    bit [3:0] m_led = 0;
    bit [1:0] m_ctl = 0;
    bit       m_hold = 0;
    bit [1:0] m_route = 0;
    bit       m_page = 0;
    bit [3:0] m_scr = 0;

    always @(posedge clk) begin
        bit do_rst, do_wr, released;
        do_rst = rst || m_sys;
        if (rst) begin
            srcq.delete();
            weq.delete();
        end else begin
            srcq.push_back(btn_rst_n && emu_rst_n && (&sup_rst_n));
            weq.push_back(bus_we_n);
        end
        if (srcq.size() > HOLD + 8) void'(srcq.pop_front());
        if (weq.size() > 6) void'(weq.pop_front());
        do_wr = (weq.size() >= 4) && weq[weq.size()-3] && !weq[weq.size()-4]
                && !bus_ce_n && bus_addr[ADDR_W-1];
        released = (srcq.size() >= HOLD + 3);
        if (released)
            for (int i = srcq.size() - 3 - HOLD; i <= srcq.size() - 3; i++)
                if (!srcq[i]) released = 0;
        m_sys = rst ? 1'b1 : !released;
        if (do_rst) begin
            m_led = 0; m_ctl = 0; m_hold = 0; m_route = 0; m_page = 0; m_scr = 0;
        end else if (do_wr) begin
            case (bus_addr[1:0])
                2'd0: m_led = bus_wdata[3:0];
                2'd1: begin m_ctl = bus_wdata[1:0]; m_hold = bus_wdata[7]; end
                2'd3: begin m_route = bus_wdata[1:0]; m_page = bus_wdata[2]; m_scr = bus_wdata[7:4]; end
                default: ;
            endcase
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9 sys_rst_n", sys_rst_n, !m_sys);
            chk("R3 led", led, m_led);
            chk("R4 card_ctl", card_ctl, m_ctl);
            chk("R5 card_rst_n", card_rst_n, !(m_sys || m_hold));
            chk("R7 route_sel", route_sel, m_route);
            chk("R7 flash_page", flash_page, m_page);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic top, input logic [1:0] idx, input logic [7:0] d);
        @(posedge clk); #1;
        bus_ce_n = 1'b0; bus_addr = {top, idx}; bus_wdata = d; bus_we_n = 1'b0;
        cyc(2);
        bus_we_n = 1'b1;
        cyc(4);
        bus_ce_n = 1'b1;
        cyc(1);
    endtask

    task automatic bus_read(input logic [1:0] idx, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        bus_ce_n = 1'b0; bus_addr = {1'b1, idx}; bus_re_n = 1'b0;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        chk("R2 oe during read", bus_rdata_oe, 1'b1);
        chk("R1 flash_ce_n in window", flash_ce_n, 1'b1);
        @(posedge clk); #1;
        bus_re_n = 1'b1; bus_ce_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset held", sys_rst_n, 1'b0);
        chk("R5 card held in reset", card_rst_n, 1'b0);
        cyc(HOLD + 6);
        chk("R9 released", sys_rst_n, 1'b1);
        chk("R10 led default", led, 4'h0);

        // R3 user register
        sw_in = 4'h9;
        cyc(3);
        bus_read(2'd0, 8'h90, "R12 switches visible");
        bus_write(1'b1, 2'd0, 8'hA5);
        chk("R3 led written", led, 4'h5);
        bus_read(2'd0, 8'h95, "R3 user readback");

        // R1 flash side: access ignored by registers
        @(posedge clk); #1;
        bus_ce_n = 1'b0; bus_addr = 3'b000; bus_re_n = 1'b0;
        @(negedge clk);
        chk("R1 flash_ce_n low", flash_ce_n, 1'b0);
        chk("R2 no drive on flash read", bus_rdata_oe, 1'b0);
        chk("R2 rdata zero", bus_rdata, 8'h00);
        @(posedge clk); #1;
        bus_re_n = 1'b1; bus_ce_n = 1'b1;
        bus_write(1'b0, 2'd0, 8'h0C);
        chk("R8 flash write ignored", led, 4'h5);

        // R2 idle bus
        @(negedge clk);
        chk("R2 idle oe", bus_rdata_oe, 1'b0);
        chk("R1 idle flash_ce_n", flash_ce_n, 1'b1);

        // R4/R5 card register
        card_det = 1'b1; card_stat = 2'b10;
        bus_write(1'b1, 2'd1, 8'hFF);
        chk("R4 card_ctl", card_ctl, 2'b11);
        chk("R5 card hold", card_rst_n, 1'b0);
        bus_read(2'd1, 8'h9B, "R4 R11 card readback");
        bus_write(1'b1, 2'd1, 8'h01);
        chk("R5 card released", card_rst_n, 1'b1);
        card_stat = 2'b01; card_det = 1'b0;
        cyc(3);
        bus_read(2'd1, 8'h05, "R12 card status");

        // R6 version
        bus_write(1'b1, 2'd2, 8'hFF);
        bus_read(2'd2, 8'h12, "R6 R11 version");

        // R7 misc
        bus_write(1'b1, 2'd3, 8'hFF);
        chk("R7 routes", route_sel, 2'b11);
        chk("R7 page", flash_page, 1'b1);
        bus_read(2'd3, 8'hF7, "R7 R11 misc readback");
        bus_write(1'b1, 2'd3, 8'h52);
        bus_read(2'd3, 8'h52, "R7 scratch pattern");

        // R9/R10 reset sources
        @(posedge clk); #1;
        emu_rst_n = 1'b0;
        cyc(1);
        emu_rst_n = 1'b1;
        cyc(3);
        chk("R9 emulator reset", sys_rst_n, 1'b0);
        cyc(HOLD + 4);
        chk("R10 routes cleared", route_sel, 2'b00);
        chk("R10 led cleared", led, 4'h0);
        bus_read(2'd3, 8'h00, "R10 misc cleared");

        sup_rst_n = 2'b01;
        cyc(5);
        chk("R9 supervisor reset", sys_rst_n, 1'b0);
        sup_rst_n = 2'b11;
        btn_rst_n = 1'b0;
        cyc(2);
        btn_rst_n = 1'b1;
        cyc(HOLD + 6);
        chk("R9 release after button", sys_rst_n, 1'b1);
        bus_write(1'b1, 2'd0, 8'h03);
        chk("R3 led after reset", led, 4'h3);
        cyc(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule